// File: doc/BRIEF.md
# Thermal fan duty controller

This block turns temperature readings into fan duty codes. Each of its channels pairs one temperature input with one duty output. A channel stays stopped, with a duty of zero, until its temperature rises above that channel's start temperature. From that point the channel runs. Its duty begins at a programmable floor and climbs by a fixed amount per degree, saturating at full scale. A running channel keeps turning at its floor duty as the temperature falls back. It stops only once the temperature reaches the start point minus a per-channel hysteresis of 0 to 15 degrees.

A fail-safe sits above the per-channel logic. A channel trips when its temperature goes above its critical limit. While any channel is tripped, every duty output is forced to full scale. A trip clears only when that channel's temperature falls below its limit minus a fixed release margin. A limit code of 0x80 switches the fail-safe off for that channel.

Each channel's settings are loaded through a simple per-channel write strobe. All comparisons and all state move only on a temperature-valid strobe. With the default of three channels, index 0 is the first remote sensor, index 1 is the local sensor and index 2 is the second remote sensor.

Top module: `fan_duty_ctrl`

## Requirements
- R1: After reset every duty output reads 0x00, and each channel's settings are floor duty 0x80 (50%), start 90 °C, critical limit 100 °C and hysteresis 4 °C. Duty codes scale so that 0x00 is off, 0x40 is 25%, 0x80 is 50% and 0xFF is full speed.
- R2: A clock edge with `cfg_we[i]` high loads channel i's floor duty, start temperature, critical limit and hysteresis from the `cfg_*` inputs. The new values govern from the next temperature strobe onward.
- R3: A stopped channel outputs duty 0x00 unless an override is active.
- R4: On a strobe where a channel's temperature is strictly above its start temperature, the channel runs. Its duty becomes floor + SLOPE × (temperature − start), clipped to 0xFF.
- R5: A running channel whose temperature is at or below its start outputs its floor duty. It stops on the strobe where its temperature is at or below start − hysteresis.
- R6: On a strobe where any channel's temperature is strictly above its enabled critical limit, that channel trips. While any trip is held, all duty outputs read 0xFF.
- R7: A tripped channel stays tripped until a strobe where its temperature is strictly below its limit − 4 °C.
- R8: A critical limit of 0x80 never trips its channel, and it clears an existing trip at the next strobe.
- R9: Without `temp_vld`, duty outputs and channel state do not change, whatever the temperature inputs do.
- R10: Temperatures, start points and limits are two's-complement °C, so negative start points work.
- R11: Duty output i (bits [8i+7:8i]) depends only on temperature input i (same bit slice), apart from the shared override.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_vld | input | 1 | Temperature strobe; all state updates on this |
| temp_flat | input | NCH*8 | Packed signed temperatures, channel i in bits [8i+7:8i] |
| cfg_we | input | NCH | Per-channel settings write enable |
| cfg_min | input | 8 | Floor duty to load |
| cfg_start | input | 8 | Signed start temperature to load |
| cfg_crit | input | 8 | Signed critical limit to load (0x80 disables) |
| cfg_hyst | input | 4 | Hysteresis in degrees to load |
| pwm_flat | output | NCH*8 | Packed duty codes, channel i in bits [8i+7:8i] |

## Verification
The bench builds the block with its default three channels and overrides SLOPE to 16. A sweep of a few tens of degrees then covers the whole ramp: the floor, the linear part and the clip at 0xFF. Each channel is swept up and back down across its start and limit. The sweeps use settings that reach a negative start, zero and maximal hysteresis, a disabled limit and a 0xFF floor. The swept channel's trip and release, and the full-duty override it forces on the idle channels, are all compared against an arithmetic model on every strobe.

// File: rtl/fan_duty_pkg.sv
package fan_duty_pkg;
  localparam int TEMP_W   = 8;
  localparam int DUTY_W   = 8;
  localparam int HYST_W   = 4;
  localparam int DUTY_MAX = (1 << DUTY_W) - 1;

  typedef struct packed {
    logic        [DUTY_W-1:0] floor_duty;
    logic signed [TEMP_W-1:0] start_t;
    logic signed [TEMP_W-1:0] limit_t;
    logic        [HYST_W-1:0] hyst;
  } chan_cfg_t;

  // floor plus slope per degree of excess, clipped to full scale
  function automatic logic [DUTY_W-1:0] ramp_duty(input logic [DUTY_W-1:0] floor_duty,
                                                 input int excess, input int slope);
    int sum;
    sum = int'(floor_duty) + excess * slope;
    if (sum > DUTY_MAX) return DUTY_W'(DUTY_MAX);
    return DUTY_W'(sum);
  endfunction
endpackage

// File: rtl/fan_cfg_store.sv
module fan_cfg_store
  import fan_duty_pkg::*;
#(
  parameter int NCH = 3,
  parameter chan_cfg_t RST_CFG = '0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [NCH-1:0] we,
  input  chan_cfg_t wdata,
  output chan_cfg_t cfg_q [NCH]
);
  for (genvar i = 0; i < NCH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q[i] <= RST_CFG;
      else if (we[i]) cfg_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/fan_chan.sv
module fan_chan
  import fan_duty_pkg::*;
#(
  parameter int SLOPE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [TEMP_W-1:0] temp,
  input  chan_cfg_t         cfg,
  output logic              start_ev,
  output logic              stop_ev,
  output logic              run_q,
  output logic [DUTY_W-1:0] duty_q
);
  localparam int XW = TEMP_W + 2;

  logic signed [XW-1:0] t_x, st_x, floor_x;
  logic                 run_nxt;
  logic [DUTY_W-1:0]    duty_nxt;

  always_comb begin
    t_x      = XW'($signed(temp));
    st_x     = XW'(cfg.start_t);
    floor_x  = st_x - $signed({{(XW-HYST_W){1'b0}}, cfg.hyst});
    start_ev = t_x > st_x;
    stop_ev  = t_x <= floor_x;
    run_nxt  = start_ev ? 1'b1 : (stop_ev ? 1'b0 : run_q);
    if (!run_nxt)      duty_nxt = '0;
    else if (start_ev) duty_nxt = ramp_duty(cfg.floor_duty, int'(t_x - st_x), SLOPE);
    else               duty_nxt = cfg.floor_duty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      duty_q <= '0;
    end else if (vld) begin
      run_q  <= run_nxt;
      duty_q <= duty_nxt;
    end
  end
endmodule

// File: rtl/fan_crit.sv
module fan_crit
  import fan_duty_pkg::*;
#(
  parameter int                REL_MARGIN = 4,
  parameter logic [TEMP_W-1:0] OFF_CODE   = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [TEMP_W-1:0] temp,
  input  chan_cfg_t         cfg,
  output logic              over_ev,
  output logic              crit_off,
  output logic              trip_q
);
  localparam int XW = TEMP_W + 2;

  logic signed [XW-1:0] t_x, lim_x, rel_x;
  logic                 clear_ev;

  always_comb begin
    t_x      = XW'($signed(temp));
    lim_x    = XW'(cfg.limit_t);
    rel_x    = lim_x - XW'(REL_MARGIN);
    crit_off = cfg.limit_t == OFF_CODE;
    over_ev  = !crit_off && (t_x > lim_x);
    clear_ev = crit_off || (t_x < rel_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          trip_q <= 1'b0;
    else if (vld) begin
      if (over_ev)       trip_q <= 1'b1;
      else if (clear_ev) trip_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl
  import fan_duty_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int SLOPE      = 8,
  parameter int REL_MARGIN = 4,
  parameter logic [DUTY_W-1:0] DEF_FLOOR = 8'h80,
  parameter logic [TEMP_W-1:0] DEF_START = 8'd90,
  parameter logic [TEMP_W-1:0] DEF_LIMIT = 8'd100,
  parameter logic [HYST_W-1:0] DEF_HYST  = 4'd4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  temp_vld,
  input  logic [NCH*TEMP_W-1:0] temp_flat,
  input  logic [NCH-1:0]        cfg_we,
  input  logic [DUTY_W-1:0]     cfg_min,
  input  logic [TEMP_W-1:0]     cfg_start,
  input  logic [TEMP_W-1:0]     cfg_crit,
  input  logic [HYST_W-1:0]     cfg_hyst,
  output logic [NCH*DUTY_W-1:0] pwm_flat
);
  localparam chan_cfg_t RST_CFG = '{floor_duty: DEF_FLOOR, start_t: DEF_START,
                                    limit_t: DEF_LIMIT, hyst: DEF_HYST};

  chan_cfg_t         wdata;
  chan_cfg_t         cfg_q [NCH];
  logic [NCH-1:0]    start_ev, stop_ev, run_q, over_ev, crit_off, trip_q;
  logic [DUTY_W-1:0] duty_q [NCH];
  logic              ovr_any;

  assign wdata = '{floor_duty: cfg_min, start_t: cfg_start, limit_t: cfg_crit, hyst: cfg_hyst};

  fan_cfg_store #(.NCH(NCH), .RST_CFG(RST_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(wdata), .cfg_q(cfg_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    fan_chan #(.SLOPE(SLOPE)) u_chan (
      .clk(clk), .rst_n(rst_n), .vld(temp_vld),
      .temp(temp_flat[i*TEMP_W +: TEMP_W]), .cfg(cfg_q[i]),
      .start_ev(start_ev[i]), .stop_ev(stop_ev[i]),
      .run_q(run_q[i]), .duty_q(duty_q[i])
    );
    fan_crit #(.REL_MARGIN(REL_MARGIN)) u_crit (
      .clk(clk), .rst_n(rst_n), .vld(temp_vld),
      .temp(temp_flat[i*TEMP_W +: TEMP_W]), .cfg(cfg_q[i]),
      .over_ev(over_ev[i]), .crit_off(crit_off[i]), .trip_q(trip_q[i])
    );
    assign pwm_flat[i*DUTY_W +: DUTY_W] = ovr_any ? DUTY_W'(DUTY_MAX) : duty_q[i];
  end

  assign ovr_any = |trip_q;
endmodule

// File: rtl/fan_duty_ctrl_chk.sv
module fan_duty_ctrl_chk #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              temp_vld,
  input logic [NCH*DW-1:0] pwm_flat,
  input logic [NCH-1:0]    start_ev,
  input logic [NCH-1:0]    stop_ev,
  input logic [NCH-1:0]    run_q,
  input logic [NCH-1:0]    over_ev,
  input logic [NCH-1:0]    crit_off,
  input logic [NCH-1:0]    trip_q
);
  assert_trip_forces_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    temp_vld && (|over_ev) |=> pwm_flat == {NCH*DW{1'b1}});

  assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_vld |=> $stable(pwm_flat) && $stable(run_q) && $stable(trip_q));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      temp_vld && start_ev[i] |=> run_q[i]);
    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      temp_vld && stop_ev[i] |=> !run_q[i]);
    assert_off_code_no_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      temp_vld && crit_off[i] |=> !trip_q[i]);
  end
endmodule

bind fan_duty_ctrl fan_duty_ctrl_chk #(.NCH(NCH), .DW(fan_duty_pkg::DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .pwm_flat(pwm_flat),
  .start_ev(start_ev), .stop_ev(stop_ev), .run_q(run_q),
  .over_ev(over_ev), .crit_off(crit_off), .trip_q(trip_q)
);

// File: tb/fan_duty_ctrl_bench.sv
module fan_duty_ctrl_bench;
  localparam int NCH = 3;
  localparam int S   = 16;
  localparam int COLD = -60;

  logic clk = 0, rst_n = 0, temp_vld = 0;
  logic [NCH*8-1:0] temp_flat = '0;
  logic [NCH-1:0]   cfg_we = '0;
  logic [7:0] cfg_min = 0, cfg_start = 0, cfg_crit = 0;
  logic [3:0] cfg_hyst = 0;
  logic [NCH*8-1:0] pwm_flat;

  int total = 0, bad = 0;
  bit done = 0;
  int mn[NCH], st[NCH], cr[NCH], hy[NCH], cur[NCH];
  bit run_m[NCH], trip_m[NCH];
  int exp_q[NCH];

  fan_duty_ctrl #(.NCH(NCH), .SLOPE(S)) u_fan_duty_ctrl (
    .clk(clk), .rst_n(rst_n), .temp_vld(temp_vld), .temp_flat(temp_flat),
    .cfg_we(cfg_we), .cfg_min(cfg_min), .cfg_start(cfg_start), .cfg_crit(cfg_crit),
    .cfg_hyst(cfg_hyst), .pwm_flat(pwm_flat)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, int ch, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s ch%0d got=%02h exp=%02h", tag, ch, got, expv);
    end
  endtask

  task automatic write_cfg(int ch, int m, int s0, int c, int h);
    @(negedge clk);
    cfg_we = '0; cfg_we[ch] = 1'b1;
    cfg_min = m[7:0]; cfg_start = s0[7:0]; cfg_crit = c[7:0]; cfg_hyst = h[3:0];
    mn[ch] = m; st[ch] = s0; cr[ch] = c; hy[ch] = h;
    @(negedge clk);
    cfg_we = '0;
  endtask

  // one strobe with the temperatures in cur[], then model and compare
  task automatic strobe(string phase, int focus);
    bit any;
    @(negedge clk);
    for (int i = 0; i < NCH; i++) temp_flat[i*8 +: 8] = cur[i][7:0];
    temp_vld = 1;
    @(negedge clk);
    temp_vld = 0;
    any = 0;
    for (int i = 0; i < NCH; i++) begin
      if (cur[i] > st[i]) run_m[i] = 1;
      else if (cur[i] + hy[i] <= st[i]) run_m[i] = 0;
      if (cr[i] == -128) trip_m[i] = 0;
      else if (cur[i] > cr[i]) trip_m[i] = 1;
      else if (cur[i] + 4 < cr[i]) trip_m[i] = 0;
      any |= trip_m[i];
    end
    for (int i = 0; i < NCH; i++) begin
      string cls;
      int e;
      if (any) begin
        e = 255;
        cls = (trip_m[i] && cur[i] <= cr[i]) ? "R7 hold" : "R6";
      end else if (!run_m[i]) begin
        e = 0; cls = "R3";
      end else if (cur[i] > st[i]) begin
        e = mn[i] + S * (cur[i] - st[i]);
        if (e > 255) e = 255;
        cls = "R4";
      end else begin
        e = mn[i]; cls = "R5";
      end
      exp_q[i] = e;
      check($sformatf("%s %s", (i == focus) ? phase : "R11", cls), i,
            int'(pwm_flat[i*8 +: 8]), e);
    end
  endtask

  task automatic sweep(int ch, int lo, int hi, string phase);
    for (int i = 0; i < NCH; i++) cur[i] = COLD;
    for (int t = lo; t <= hi; t++) begin cur[ch] = t; strobe(phase, ch); end
    for (int t = hi; t >= lo; t--) begin cur[ch] = t; strobe(phase, ch); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      mn[i] = 128; st[i] = 90; cr[i] = 100; hy[i] = 4;
      run_m[i] = 0; trip_m[i] = 0; cur[i] = COLD;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NCH; i++) check("R1 reset", i, int'(pwm_flat[i*8 +: 8]), 0);

    // defaults: start 90, limit 100, hyst 4, floor 0x80
    sweep(1, 70, 110, "R1");
    sweep(0, 80, 106, "R1 R7");

    // negative start, widest hysteresis, disabled limit
    write_cfg(0, 8'h40, -10, -128, 15);
    sweep(0, -40, 127, "R8 R10");

    // zero hysteresis, close limit
    write_cfg(2, 8'h20, 30, 40, 0);
    sweep(2, 20, 60, "R2");

    // full floor, limit at top of range
    write_cfg(1, 8'hFF, 0, 127, 3);
    sweep(1, -5, 127, "R2");

    // disable a latched trip: ch2 trips, then its limit is switched off
    for (int i = 0; i < NCH; i++) cur[i] = COLD;
    cur[2] = 50; strobe("R6", 2);
    write_cfg(2, 8'h20, 30, -128, 0);
    strobe("R8 clear", 2);

    // no strobe: temperatures move, outputs must not
    cur[2] = 35; strobe("R9 setup", 2);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) temp_flat[i*8 +: 8] = 8'(100 + 3 * k);
      @(negedge clk);
      for (int i = 0; i < NCH; i++) check("R9 no strobe", i, int'(pwm_flat[i*8 +: 8]), exp_q[i]);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule